// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the 20-bit physical address of a memory operand for a 16-bit core that uses segmented memory. Each request brings an addressing-mode code, the four pointer/index register values, a displacement, the four segment register values and an optional segment override. The block adds the selected offset terms in 16 bits, picks a segment, shifts that segment value left by four bits, and adds the offset.

The result is registered. A request is presented with `in_valid` high, and its address appears one clock later with `out_valid` high. When no request is offered, the last result stays on the outputs. The chosen segment is also reported as a code, so the memory stage can apply per-segment rules.

Top module: `seg_ea_gen`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low after an edge that sampled it low.
- R2: `out_addr` = (segment value × 16 + offset) modulo 2^20.
- R3: Mode 3'b000 (direct) uses all 16 bits of `disp` as the offset, whatever `disp_wide` is. Codes 3'b101 to 3'b111 behave the same as mode 3'b000.
- R4: Mode 3'b001 (register indirect) uses one register as the offset. `reg_sel` selects it: 2'b00 BX, 2'b01 BP, 2'b10 SI, 2'b11 DI.
- R5: Mode 3'b010 (register relative) adds the displacement to the register picked by `reg_sel`. With `disp_wide`=0 only `disp[7:0]` is used, sign-extended to 16 bits, and `disp[15:8]` has no effect. With `disp_wide`=1 all 16 bits are used.
- R6: Mode 3'b011 (based indexed) adds a base register to an index register. The base is BX when `base_sel`=0 and BP when it is 1. The index is SI when `idx_sel`=0 and DI when it is 1. Mode 3'b100 adds the displacement as well, with the width rule of R5.
- R7: The offset sum wraps modulo 2^16 before the segment base is added.
- R8: With `ovr_en`=0 the segment is SS when BP is one of the offset terms, and DS otherwise. `out_seg` reports the segment as a code: 2'b00 ES, 2'b01 CS, 2'b10 SS, 2'b11 DS.
- R9: With `ovr_en`=1 the segment named by `ovr_seg` (same codes as R8) is used, whatever the mode.
- R10: While `in_valid` is low, `out_addr` and `out_seg` keep their last values even when the other inputs change.
- R11: While `rst_n` is low, `out_valid`, `out_addr` and `out_seg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code |
| reg_sel | input | 2 | Register for single-register modes |
| base_sel | input | 1 | Base register for based-indexed modes |
| idx_sel | input | 1 | Index register for based-indexed modes |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: sign-extended 8-bit |
| disp | input | 16 | Displacement |
| bx | input | 16 | BX value |
| bp | input | 16 | BP value |
| si | input | 16 | SI value |
| di | input | 16 | DI value |
| cs | input | 16 | CS value |
| ds | input | 16 | DS value |
| ss | input | 16 | SS value |
| es | input | 16 | ES value |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_addr | output | 20 | Physical address |
| out_seg | output | 2 | Segment code used |

## Verification
Several mechanisms can act on the same request in a single cycle, and each pairing is exercised explicitly:

- **Default versus override.** A BP-based mode selects the stack segment by default, but an override can redirect it. Vectors that use BP with an override naming DS must report DS, not SS.
- **Override equal to the default.** An override that names SS on a BP-based mode must still report SS.
- **Sign extension with wrap-around.** A negative 8-bit displacement added to BP exercises sign extension and 16-bit offset wrap in one request.
- **Offset wrap with segment default.** A separate case wraps the offset while the segment still defaults to SS.

Each result is compared one cycle after its request against an address worked out by hand. The vectors run back to back, so any state left over from the previous request would show up in the next comparison.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  localparam int OFF_W   = 16;
  localparam int SEG_W   = 16;
  localparam int SHIFT   = 4;
  localparam int NARROW  = 8;
  localparam int NSEG    = 4;
  localparam int SCODE_W = $clog2(NSEG);

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'b000,
    AM_REG_IND  = 3'b001,
    AM_REG_REL  = 3'b010,
    AM_BIDX     = 3'b011,
    AM_BIDX_D   = 3'b100
  } addr_mode_e;

  localparam logic [1:0] RSEL_BX = 2'b00;
  localparam logic [1:0] RSEL_BP = 2'b01;
  localparam logic [1:0] RSEL_SI = 2'b10;
  localparam logic [1:0] RSEL_DI = 2'b11;

  localparam logic [SCODE_W-1:0] SEG_ES = 2'b00;
  localparam logic [SCODE_W-1:0] SEG_CS = 2'b01;
  localparam logic [SCODE_W-1:0] SEG_SS = 2'b10;
  localparam logic [SCODE_W-1:0] SEG_DS = 2'b11;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seg_offset_calc.sv
module seg_offset_calc
  import seg_ea_pkg::*;
#(
  parameter int W  = OFF_W,
  parameter int NW = NARROW
) (
  input  logic [2:0]   mode,
  input  logic [1:0]   reg_sel,
  input  logic         base_sel,
  input  logic         idx_sel,
  input  logic         disp_wide,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] bp,
  input  logic [W-1:0] si,
  input  logic [W-1:0] di,
  output logic [W-1:0] offset,
  output logic         bp_used
);
  localparam int EXT_W = W - NW;

  logic [W-1:0] disp_ext;
  logic [W-1:0] single_reg;
  logic [W-1:0] base_reg;
  logic [W-1:0] idx_reg;
  logic [W-1:0] term_a, term_b, term_c;
  addr_mode_e   mode_e;

  assign mode_e   = addr_mode_e'(mode);
  assign disp_ext = disp_wide ? disp : {{EXT_W{disp[NW-1]}}, disp[NW-1:0]};
  assign base_reg = base_sel ? bp : bx;
  assign idx_reg  = idx_sel  ? di : si;

  always_comb begin
    unique case (reg_sel)
      RSEL_BX: single_reg = bx;
      RSEL_BP: single_reg = bp;
      RSEL_SI: single_reg = si;
      default: single_reg = di;
    endcase
  end

  always_comb begin
    term_a  = '0;
    term_b  = '0;
    term_c  = disp;
    bp_used = 1'b0;
    case (mode_e)
      AM_REG_IND: begin
        term_a  = single_reg;
        term_c  = '0;
        bp_used = (reg_sel == RSEL_BP);
      end
      AM_REG_REL: begin
        term_a  = single_reg;
        term_c  = disp_ext;
        bp_used = (reg_sel == RSEL_BP);
      end
      AM_BIDX: begin
        term_a  = base_reg;
        term_b  = idx_reg;
        term_c  = '0;
        bp_used = base_sel;
      end
      AM_BIDX_D: begin
        term_a  = base_reg;
        term_b  = idx_reg;
        term_c  = disp_ext;
        bp_used = base_sel;
      end
      default: begin
        term_c  = disp;
      end
    endcase
  end

  assign offset = term_a + term_b + term_c;
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_ea_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NSEG,
  parameter int CW = SCODE_W
) (
  input  logic          ovr_en,
  input  logic [CW-1:0] ovr_seg,
  input  logic          bp_used,
  input  logic [W-1:0]  cs,
  input  logic [W-1:0]  ds,
  input  logic [W-1:0]  ss,
  input  logic [W-1:0]  es,
  output logic [CW-1:0] seg_code,
  output logic [W-1:0]  seg_val
);
  logic [N-1:0][W-1:0] bank;
  logic [N-1:0][W-1:0] masked;

  assign bank[SEG_ES] = es;
  assign bank[SEG_CS] = cs;
  assign bank[SEG_SS] = ss;
  assign bank[SEG_DS] = ds;

  always_comb begin
    if (ovr_en)       seg_code = ovr_seg;
    else if (bp_used) seg_code = SEG_SS;
    else              seg_code = SEG_DS;
  end

  for (genvar g = 0; g < N; g++) begin : g_seg_lane
    assign masked[g] = (seg_code == CW'(g)) ? bank[g] : '0;
  end

  always_comb begin
    seg_val = '0;
    for (int k = 0; k < N; k++) seg_val = seg_val | masked[k];
  end
endmodule

// File: rtl/seg_phys_add.sv
module seg_phys_add #(
  parameter int SW = 16,
  parameter int OW = 16,
  parameter int SH = 4,
  localparam int PW = SW + SH
) (
  input  logic [SW-1:0] seg_val,
  input  logic [OW-1:0] offset,
  output logic [PW-1:0] phys
);
  logic [PW-1:0] base_w;
  logic [PW-1:0] off_w;

  if (SH > 0) begin : g_shift
    assign base_w = {seg_val, {SH{1'b0}}};
  end else begin : g_noshift
    assign base_w = seg_val;
  end

  if (PW > OW) begin : g_pad
    assign off_w = {{(PW-OW){1'b0}}, offset};
  end else begin : g_trunc
    assign off_w = offset[PW-1:0];
  end

  assign phys = base_w + off_w;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int RW = OFF_W,
  parameter int SW = SEG_W,
  parameter int SH = SHIFT,
  localparam int PW = SW + SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    mode,
  input  logic [1:0]    reg_sel,
  input  logic          base_sel,
  input  logic          idx_sel,
  input  logic          disp_wide,
  input  logic [RW-1:0] disp,
  input  logic [RW-1:0] bx,
  input  logic [RW-1:0] bp,
  input  logic [RW-1:0] si,
  input  logic [RW-1:0] di,
  input  logic [SW-1:0] cs,
  input  logic [SW-1:0] ds,
  input  logic [SW-1:0] ss,
  input  logic [SW-1:0] es,
  input  logic          ovr_en,
  input  logic [1:0]    ovr_seg,
  output logic          out_valid,
  output logic [PW-1:0] out_addr,
  output logic [1:0]    out_seg
);
  logic          rst_sync_n;
  logic [RW-1:0] offset;
  logic          bp_used;
  logic [1:0]    seg_code;
  logic [SW-1:0] seg_val;
  logic [PW-1:0] phys;

  logic          valid_d, valid_q;
  logic [PW-1:0] addr_d,  addr_q;
  logic [1:0]    seg_d,   seg_q;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  seg_offset_calc #(.W(RW), .NW(NARROW)) u_off (
    .mode(mode), .reg_sel(reg_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp_wide(disp_wide), .disp(disp),
    .bx(bx), .bp(bp), .si(si), .di(di),
    .offset(offset), .bp_used(bp_used)
  );

  seg_select #(.W(SW), .N(NSEG), .CW(SCODE_W)) u_sel (
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .bp_used(bp_used),
    .cs(cs), .ds(ds), .ss(ss), .es(es),
    .seg_code(seg_code), .seg_val(seg_val)
  );

  seg_phys_add #(.SW(SW), .OW(RW), .SH(SH)) u_add (
    .seg_val(seg_val), .offset(offset), .phys(phys)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    addr_d  = addr_q;
    seg_d   = seg_q;
    if (in_valid) begin
      addr_d = phys;
      seg_d  = seg_code;
    end
  end

  // registers: async assert, release through synchroniser
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      seg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        addr_q <= addr_d;
        seg_q  <= seg_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_seg   = seg_q;

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  // R1
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_seg)));
  // R8
  a_r8_bp_default: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !ovr_en && bp_used) |=> (out_seg == SEG_SS));
  // R8
  a_r8_ds_default: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !ovr_en && !bp_used) |=> (out_seg == SEG_DS));
  // R9
  a_r9_override: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && ovr_en) |=> (out_seg == $past(ovr_seg)));
  // R2: low address bits come straight from the offset
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (out_addr[SH-1:0] == $past(offset[SH-1:0])));
endmodule

// File: tb/tb_seg_ea_gen.sv
module tb_seg_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [1:0]  reg_sel;
  logic        base_sel, idx_sel, disp_wide;
  logic [15:0] disp, bx, bp, si, di, cs, ds, ss, es;
  logic        ovr_en;
  logic [1:0]  ovr_seg;
  logic        out_valid;
  logic [19:0] out_addr;
  logic [1:0]  out_seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  seg_ea_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .reg_sel(reg_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp_wide(disp_wide), .disp(disp), .bx(bx), .bp(bp), .si(si), .di(di),
    .cs(cs), .ds(ds), .ss(ss), .es(es), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .out_addr(out_addr), .out_seg(out_seg)
  );

  // {mode,rsel,bsel,isel,wide,oen,oseg,disp,exp_addr,exp_seg}
  // regs BX=2000 BP=1000 SI=0120 DI=0005; CS=1000 DS=2000 SS=3000 ES=4000
  localparam int NV = 20;
  localparam logic [48:0] VEC [NV] = '{
    {3'd0,2'd0,1'b0,1'b0,1'b1,1'b0,2'd0,16'h1234,20'h21234,2'd3},
    {3'd0,2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0080,20'h20080,2'd3},
    {3'd1,2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,20'h22000,2'd3},
    {3'd1,2'd1,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,20'h31000,2'd2},
    {3'd1,2'd2,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,20'h20120,2'd3},
    {3'd1,2'd3,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,20'h20005,2'd3},
    {3'd2,2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0020,20'h22020,2'd3},
    {3'd2,2'd1,1'b0,1'b0,1'b0,1'b0,2'd0,16'h00F0,20'h30FF0,2'd2},
    {3'd2,2'd2,1'b0,1'b0,1'b1,1'b0,2'd0,16'h8000,20'h28120,2'd3},
    {3'd2,2'd3,1'b0,1'b0,1'b1,1'b0,2'd0,16'hFFFF,20'h20004,2'd3},
    {3'd3,2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,20'h22120,2'd3},
    {3'd3,2'd0,1'b1,1'b1,1'b0,1'b0,2'd0,16'h0000,20'h31005,2'd2},
    {3'd4,2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0010,20'h22130,2'd3},
    {3'd4,2'd0,1'b1,1'b1,1'b1,1'b0,2'd0,16'h0125,20'h3112A,2'd2},
    {3'd4,2'd0,1'b0,1'b1,1'b0,1'b1,2'd1,16'h0002,20'h12007,2'd1},
    {3'd1,2'd1,1'b0,1'b0,1'b0,1'b1,2'd3,16'h0000,20'h21000,2'd3},
    {3'd0,2'd0,1'b0,1'b0,1'b1,1'b1,2'd0,16'h1234,20'h41234,2'd0},
    {3'd3,2'd0,1'b1,1'b0,1'b0,1'b1,2'd2,16'h0000,20'h31120,2'd2},
    {3'd2,2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'hAB7F,20'h2207F,2'd3},
    {3'd5,2'd1,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0042,20'h20042,2'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m, input logic oe);
    if (oe) return "R9";
    case (m)
      3'd1:         return "R4";
      3'd2:         return "R5";
      3'd3, 3'd4:   return "R6";
      default:      return "R3";
    endcase
  endfunction

  task automatic set_regs();
    bx = 16'h2000; bp = 16'h1000; si = 16'h0120; di = 16'h0005;
    cs = 16'h1000; ds = 16'h2000; ss = 16'h3000; es = 16'h4000;
  endtask

  task automatic drive(input logic [2:0] m, input logic [1:0] rs, input logic bs,
                       input logic is, input logic w, input logic oe,
                       input logic [1:0] os, input logic [15:0] d);
    mode = m; reg_sel = rs; base_sel = bs; idx_sel = is; disp_wide = w;
    ovr_en = oe; ovr_seg = os; disp = d;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    set_regs();
    drive(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", 32'(out_valid), 32'd0);
    check("R11 addr",  32'(out_addr),  32'd0);
    check("R11 seg",   32'(out_seg),   32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 32'(out_valid), 32'd0);

    // table, back to back
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      drive(v[48:46], v[45:44], v[43], v[42], v[41], v[40], v[39:38], v[37:22]);
      in_valid = 1'b1;
      @(negedge clk);
      check("R1 valid", 32'(out_valid), 32'd1);
      check($sformatf("%s R2 addr vec%0d", req_of(v[48:46], v[40]), i),
            32'(out_addr), 32'(v[21:2]));
      check($sformatf("%s seg vec%0d", v[40] ? "R9" : "R8", i),
            32'(out_seg), 32'(v[1:0]));
    end

    // R10 hold while idle, inputs disturbed
    in_valid = 1'b0;
    drive(3'd4, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 16'h5555);
    bx = 16'hDEAD;
    @(negedge clk);
    check("R1 drop", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R10 addr hold", 32'(out_addr), 32'h20042);
    check("R10 seg hold",  32'(out_seg),  32'd3);
    set_regs();

    // example: BP=1598 DI=1004 -> SS:259C
    bp = 16'h1598; di = 16'h1004;
    drive(3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R6 bp+di example", 32'(out_addr), 32'h3259C);
    check("R8 bp+di seg", 32'(out_seg), 32'd2);

    // R2 20-bit wrap: SS=FFFF, BP=FFFF
    set_regs(); ss = 16'hFFFF; bp = 16'hFFFF;
    drive(3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
    @(negedge clk);
    check("R2 20-bit wrap", 32'(out_addr), 32'h0FFEF);

    // R7 three-term offset wrap: FFFF+FFFF+FFFF -> FFFD in DS
    set_regs(); bx = 16'hFFFF; si = 16'hFFFF;
    drive(3'd4, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 16'hFFFF);
    @(negedge clk);
    check("R7 offset wrap", 32'(out_addr), 32'h2FFFD);
    in_valid = 1'b0;

    // R11 asynchronous reset mid-run
    @(posedge clk); #1;
    rst_n = 1'b0; #1;
    check("R11 async valid", 32'(out_valid), 32'd0);
    check("R11 async addr",  32'(out_addr),  32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    finish_up();
  end
endmodule